// File: doc/BRIEF.md
# Trimmed Seconds Counter for a Real-Time Clock

This block keeps wall-clock time as a 32-bit count of seconds. The count advances from a slow reference clock, nominally 32.768 kHz. A prescaler divides that clock down to one tick per second. The nominal second lasts 2^PRESC_BITS reference cycles.

To correct for crystal error, software programs a signed cycle trim and a repeat interval. The second that closes each interval is stretched or shortened by the trim. Every other second keeps the nominal length.

Two active-low guard bits protect the setup. Software can clear a guard bit but cannot set it again; only reset restores it. One bit freezes the trim settings. The other freezes the guard register itself.

Software reaches the block through a single-cycle register port with no back-pressure:
- A write is taken on the rising clock edge whenever `bus_wr` is high.
- A read is combinational: `bus_rdata` always shows the register that `bus_addr` selects.

There is no data stream, so no valid/ready handshake is needed.

The register map is:

| Address | Register | Contents |
|---|---|---|
| 0 | seconds | the 32-bit count |
| 1 | status | bit 0 = count enable (read/write), bit 1 = wrap flag (read-only) |
| 2 | trim | bits 7:0 = signed trim, bits 15:8 = interval minus one |
| 3 | guard | bit 0 = trim writable, bit 1 = guard writable |

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset the registers read as follows: seconds = 1, status = 0, trim = 0, guard = 3.
- R2: With trim 0 and counting enabled, the seconds register increments once every 2^PRESC_BITS clock cycles. The first increment comes 2^PRESC_BITS edges after the edge that sets the enable.
- R3: A trimmed second lasts 2^PRESC_BITS minus the signed 8-bit trim value. Trim 0x01 gives one cycle fewer, 0x7F gives 127 fewer, 0xFF gives one more and 0x80 gives 128 more.
- R4: With interval field N (0 to 255), exactly one second in every N+1 uses the trimmed length, and it is the last second of each group. All other seconds use 2^PRESC_BITS cycles.
- R5: While the enable bit (status bit 0) is 0, the seconds value and the prescaler hold. Setting the bit again resumes the second already in progress.
- R6: A write to the seconds register while the enable bit is 1 is ignored.
- R7: A write to the seconds register while counting is stopped restarts the prescaler and the interval position. The next second after enabling therefore lasts a full period and is the first of a new interval group.
- R8: When guard bit 0 is 0, writes to the trim register are ignored.
- R9: A write to the guard register can only clear bits, never set them. When guard bit 1 is 0, writes to the guard register are ignored.
- R10: When the seconds value steps from 0xFFFFFFFF, it becomes 0 and sets status bit 1. That bit stays set until the seconds register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 seconds, 1 status, 2 trim, 3 guard |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |

## Verification
The second length is measured edge by edge under trim values 0, +1, +127, -1 and -128. This shows whether the sign of the trim is handled correctly and whether the base period is off by one. The trim 0x10 is then run with intervals of two and three seconds over several groups. This shows whether the trimmed second lands on the last second of each group rather than the first, and whether it appears exactly once per group.

Stopping the count and reloading the seconds register, both mid-second and mid-group, separates the hold behaviour from the restart behaviour. A run from 0xFFFFFFFF exercises the wrap and its sticky flag. Each guard bit is cleared on its own, so a freeze of the trim register can be told apart from a freeze of the guard register.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    REG_SECS  = 2'd0,
    REG_STAT  = 2'd1,
    REG_TRIM  = 2'd2,
    REG_GUARD = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [7:0] ival;  // interval length minus one, in seconds
    logic [7:0] trim;  // signed cycle correction
  } trim_cfg_t;

  localparam logic [1:0] GUARD_RESET = 2'b11;
  localparam logic [31:0] SECS_RESET = 32'd1;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int PRESC_BITS = 15  // at least 8, so that base period > 128
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      restart,
  input  trim_cfg_t cfg,
  output logic      tick
);

  localparam int CW = PRESC_BITS + 1;
  localparam int PW = PRESC_BITS + 2;
  localparam logic [PW-1:0] BASE = PW'(1) << PRESC_BITS;

  logic [CW-1:0] cnt_q;
  logic [7:0]    grp_q;
  logic [PW-1:0] trim_ext;
  logic [PW-1:0] trimmed_len;
  logic [PW-1:0] active_len;
  logic          last_cycle;
  logic          grp_end;

  assign trim_ext    = {{(PW-8){cfg.trim[7]}}, cfg.trim};
  assign trimmed_len = BASE - trim_ext;
  assign grp_end     = (grp_q == cfg.ival);
  assign active_len  = grp_end ? trimmed_len : BASE;
  assign last_cycle  = ({1'b0, cnt_q} >= (active_len - PW'(1)));
  assign tick        = en && last_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      grp_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      grp_q <= '0;
    end else if (en) begin
      if (last_cycle) begin
        cnt_q <= '0;
        grp_q <= grp_end ? 8'd0 : grp_q + 8'd1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R2: a completed second restarts the prescaler from zero
  a_r2_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

  // R5: with counting stopped and no restart the prescaler holds
  a_r5_prescaler_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> ($stable(cnt_q) && $stable(grp_q)));

  // R7: a reload puts the interval position back to the first second
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && grp_q == 8'd0));

endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        load,
  input  logic [31:0] load_val,
  output logic [31:0] secs,
  output logic        wrapped
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs    <= SECS_RESET;
      wrapped <= 1'b0;
    end else if (load) begin
      secs    <= load_val;
      wrapped <= 1'b0;
    end else if (tick) begin
      secs <= secs + 32'd1;
      if (secs == '1) wrapped <= 1'b1;
    end
  end

  // R2: every tick adds exactly one second
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (secs == $past(secs) + 32'd1));

  // R10: stepping from all ones lands on zero with the flag set
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && secs == '1) |=> (secs == 32'd0 && wrapped));

  // R10: the flag is sticky until the seconds register is written
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !load) |=> wrapped);

  // R5: no tick and no load means the count holds
  a_r5_secs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(secs));

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] secs,
  input  logic        wrapped,
  output logic        en,
  output trim_cfg_t   cfg,
  output logic        secs_load
);

  logic [1:0] guard_q;  // bit0: trim writable, bit1: guard writable
  logic       wr_stat, wr_trim, wr_guard;

  assign wr_stat   = bus_wr && (bus_addr == REG_STAT);
  assign wr_trim   = bus_wr && (bus_addr == REG_TRIM)  && guard_q[0];
  assign wr_guard  = bus_wr && (bus_addr == REG_GUARD) && guard_q[1];
  assign secs_load = bus_wr && (bus_addr == REG_SECS)  && !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      cfg     <= '0;
      guard_q <= GUARD_RESET;
    end else begin
      if (wr_stat)  en      <= bus_wdata[0];
      if (wr_trim)  cfg     <= bus_wdata[15:0];
      if (wr_guard) guard_q <= guard_q & bus_wdata[1:0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_SECS:  bus_rdata = secs;
      REG_STAT:  bus_rdata = {30'd0, wrapped, en};
      REG_TRIM:  bus_rdata = {16'd0, cfg};
      default:   bus_rdata = {30'd0, guard_q};
    endcase
  end

  // R8: a closed trim guard freezes the trim settings
  a_r8_trim_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_q[0] |=> $stable(cfg));

  // R9: a closed guard-register guard freezes the guard bits
  a_r9_guard_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_q[1] |=> $stable(guard_q));

  // R9: guard bits never return to 1 outside reset
  generate
    for (genvar g = 0; g < 2; g++) begin : g_guard_chk
      a_r9_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !guard_q[g] |=> !guard_q[g]);
    end
  endgenerate

endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
  import rtc_pkg::*;
#(
  parameter int PRESC_BITS = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  logic        en;
  logic        secs_load;
  logic        tick;
  logic        wrapped;
  logic [31:0] secs;
  trim_cfg_t   cfg;

  rtc_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .secs      (secs),
    .wrapped   (wrapped),
    .en        (en),
    .cfg       (cfg),
    .secs_load (secs_load)
  );

  rtc_prescaler #(.PRESC_BITS(PRESC_BITS)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .restart (secs_load),
    .cfg     (cfg),
    .tick    (tick)
  );

  rtc_seconds u_secs (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (secs_load),
    .load_val (bus_wdata),
    .secs     (secs),
    .wrapped  (wrapped)
  );

  // R6: while counting, a bus write never changes the count by more than a tick
  a_r6_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bus_wr && bus_addr == REG_SECS && !tick) |=> $stable(secs));

endmodule

// File: tb/sim_rtc_seconds_core.sv
`timescale 1ns/1ps
module sim_rtc_seconds_core;

  localparam int PB   = 9;
  localparam int BASE = 1 << PB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  rtc_seconds_core #(.PRESC_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // edges until the seconds value changes
  task automatic measure(output int n);
    logic [31:0] old;
    bus_addr = 2'd0;
    #0.1 old = bus_rdata;
    n = 0;
    while (n < 4000) begin
      @(posedge clk); #1;
      n++;
      if (bus_rdata != old) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic restart_secs(logic [31:0] v);
    wr(2'd1, 32'd0);
    wr(2'd0, v);
    wr(2'd1, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 seconds", d, 32'd1);
    rd(2'd1, d); chk("R1 status", d, 32'd0);
    rd(2'd2, d); chk("R1 trim", d, 32'd0);
    rd(2'd3, d); chk("R1 guard", d, 32'd3);
  endtask

  task automatic t_base();
    int n;
    logic [31:0] d;
    restart_secs(32'd0);
    measure(n); chk("R2 first second", n, BASE);
    measure(n); chk("R2 second period", n, BASE);
    rd(2'd0, d); chk("R2 count", d, 32'd2);
    wr(2'd1, 32'd0);
  endtask

  task automatic t_trim();
    int n;
    logic [7:0] tv [4] = '{8'h01, 8'h7F, 8'hFF, 8'h80};
    int         ex [4] = '{BASE - 1, BASE - 127, BASE + 1, BASE + 128};
    for (int i = 0; i < 4; i++) begin
      wr(2'd1, 32'd0);
      wr(2'd2, {24'd0, tv[i]});
      restart_secs(32'd0);
      measure(n); chk("R3 trimmed length", n, ex[i]);
      measure(n); chk("R3 trimmed length repeat", n, ex[i]);
    end
    wr(2'd1, 32'd0);
  endtask

  task automatic t_interval();
    int n;
    wr(2'd2, {16'd0, 8'd2, 8'h10});
    restart_secs(32'd0);
    for (int i = 0; i < 6; i++) begin
      measure(n);
      chk("R4 interval of three", n, (i % 3 == 2) ? BASE - 16 : BASE);
    end
    wr(2'd1, 32'd0);
  endtask

  task automatic t_restart();
    int n;
    wr(2'd2, {16'd0, 8'd1, 8'h10});
    restart_secs(32'd0);
    measure(n); chk("R4 group start", n, BASE);
    restart_secs(32'd7);
    measure(n); chk("R7 group restarted", n, BASE);
    measure(n); chk("R7 group end trimmed", n, BASE - 16);
    repeat (100) @(negedge clk);
    restart_secs(32'd7);
    measure(n); chk("R7 mid-second reload full", n, BASE);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
  endtask

  task automatic t_enable();
    int n;
    logic [31:0] s, d;
    restart_secs(32'd20);
    repeat (100) @(negedge clk);
    wr(2'd1, 32'd0);
    rd(2'd0, s);
    repeat (1500) @(negedge clk);
    rd(2'd0, d); chk("R5 held while stopped", d, s);
    wr(2'd1, 32'd1);
    measure(n);
    chk("R5 resumes partial second", (n > 0 && n < BASE) ? 32'd1 : 32'd0, 32'd1);
    wr(2'd1, 32'd0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    restart_secs(32'd10);
    wr(2'd0, 32'h1234);
    rd(2'd0, d); chk("R6 write while counting", d, 32'd10);
    rd(2'd1, d); chk("R6 still enabled", d, 32'd1);
    wr(2'd1, 32'd0);
  endtask

  task automatic t_wrap();
    int n;
    logic [31:0] d;
    restart_secs(32'hFFFF_FFFF);
    rd(2'd1, d); chk("R10 flag clear before wrap", d, 32'd1);
    measure(n);
    rd(2'd0, d); chk("R10 wraps to zero", d, 32'd0);
    rd(2'd1, d); chk("R10 flag set", d, 32'd3);
    wr(2'd1, 32'd0);
    rd(2'd1, d); chk("R10 flag sticky", d, 32'd2);
    wr(2'd0, 32'd5);
    rd(2'd1, d); chk("R10 flag cleared by write", d, 32'd0);
  endtask

  task automatic t_guards();
    logic [31:0] d;
    wr(2'd3, 32'd2);
    rd(2'd3, d); chk("R9 clear trim guard", d, 32'd2);
    wr(2'd2, 32'h0533);
    rd(2'd2, d); chk("R8 trim write ignored", d, 32'd0);
    wr(2'd3, 32'd3);
    rd(2'd3, d); chk("R9 cannot set bits", d, 32'd2);
    wr(2'd3, 32'd0);
    rd(2'd3, d); chk("R9 clear both", d, 32'd0);
    do_reset();
    wr(2'd3, 32'd1);
    rd(2'd3, d); chk("R9 clear guard-register guard", d, 32'd1);
    wr(2'd3, 32'd0);
    rd(2'd3, d); chk("R9 guard write ignored", d, 32'd1);
    wr(2'd2, 32'h0007);
    rd(2'd2, d); chk("R8 trim still writable", d, 32'h0007);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_base();
    t_trim();
    t_interval();
    t_restart();
    t_enable();
    t_ignored();
    t_wrap();
    t_guards();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule